// File: doc/BRIEF.md
# GPIO Bank with Edge Detection

A bank of up to 32 general-purpose pins behind a small memory-mapped register port. Software reads the synchronised pin levels, chooses per pin whether it drives (output) or listens (input), and moves output levels only through two write-only registers: one whose ones drive pins high and one whose ones drive pins low. No read-modify-write of the output data is ever needed.

Each pin can watch for rising transitions, falling transitions or both, under two independent enable masks. A seen transition is held in a sticky per-pin status bit until software writes a one to that bit, and a single interrupt line is raised while any status bit is held. Pin inputs pass through a synchroniser before they are sampled or compared, so an edge reaches the status register three clock edges after the pin moves.

The register port is single-cycle: a write takes effect at the clock edge where `reg_we` is high, and read data follows the address combinationally.

Top module: `gpio_edge_bank`

## Requirements
- R1: After reset every pin is an input (`pin_oe` all zero), the output data is zero, both edge enable masks and all status bits are zero, and `irq` is low.
- R2: A write to offset 0x18 drives high every output bit whose write-data bit is 1; bits written 0 keep their previous output value.
- R3: A write to offset 0x24 drives low every output bit whose write-data bit is 1; bits written 0 keep their value. Offsets 0x18 and 0x24 read as zero.
- R4: Offset 0x0C holds the direction mask, readable and writable; a bit of 1 sets the matching `pin_oe` bit (output), a bit of 0 clears it (input).
- R5: Offset 0x00 reads the synchronised pin levels; a pin change made before clock edge k is visible on a read after edge k+1 and not after edge k.
- R6: Offset 0x30 holds the rising enable mask; a low-to-high pin transition sets its status bit only when its rising enable bit is 1.
- R7: Offset 0x3C holds the falling enable mask; a high-to-low transition sets its status bit only when its falling enable bit is 1, and with both bits set either transition is recorded.
- R8: Offset 0x48 reads the status bits; writing 1 to a status bit clears it, writing 0 leaves it, and writing all ones clears every pending bit. Status bits hold until cleared.
- R9: When a recorded transition and a clearing write to the same status bit fall on the same clock edge, the bit ends set.
- R10: `irq` is high exactly while at least one status bit is set.
- R11: Register bits at or above NUM_PINS read as zero and ignore writes; any other offset reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data for `reg_addr` |
| pin_in | input | NUM_PINS | Asynchronous pin levels |
| pin_out | output | NUM_PINS | Output data per pin |
| pin_oe | output | NUM_PINS | Output enable per pin (1 = drive) |
| irq | output | 1 | Combined edge interrupt |

## Verification
The two functions that can meet in one cycle are a transition reaching the status register and a software write that clears the same status bit. The bench provokes this by moving a pin and placing the clearing write exactly on the third clock edge after the move, then reads the status register and expects the bit still set, and contrasts it with a clear made on a quiet cycle that must empty the bit. A randomised phase with pin toggles and writes to every offset lands further collisions by chance, and the behavioural model compared on every clock judges each one.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

   localparam logic [7:0] OFF_LEVEL = 8'h00;
   localparam logic [7:0] OFF_DIR   = 8'h0C;
   localparam logic [7:0] OFF_SET   = 8'h18;
   localparam logic [7:0] OFF_CLR   = 8'h24;
   localparam logic [7:0] OFF_RISE  = 8'h30;
   localparam logic [7:0] OFF_FALL  = 8'h3C;
   localparam logic [7:0] OFF_STAT  = 8'h48;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_LEVEL,
      SEL_DIR,
      SEL_SET,
      SEL_CLR,
      SEL_RISE,
      SEL_FALL,
      SEL_STAT
   } reg_sel_e;

   function automatic reg_sel_e decode_offset(input logic [7:0] off);
      reg_sel_e s;
      case (off)
         OFF_LEVEL: s = SEL_LEVEL;
         OFF_DIR:   s = SEL_DIR;
         OFF_SET:   s = SEL_SET;
         OFF_CLR:   s = SEL_CLR;
         OFF_RISE:  s = SEL_RISE;
         OFF_FALL:  s = SEL_FALL;
         OFF_STAT:  s = SEL_STAT;
         default:   s = SEL_NONE;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
   parameter int unsigned WIDTH  = 16,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   localparam int unsigned CHAIN_W = WIDTH * STAGES;

   if (STAGES < 1) begin : g_bad_stages
      $error("gpio_pin_sync: STAGES must be at least 1");
   end

   if (STAGES == 1) begin : g_single
      logic [WIDTH-1:0] q1;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q1 <= '0;
         else        q1 <= d_i;
      end
      assign q_o = q1;
   end else begin : g_chain
      logic [CHAIN_W-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '0;
         else        chain <= {chain[CHAIN_W-WIDTH-1:0], d_i};
      end
      assign q_o = chain[CHAIN_W-1 -: WIDTH];

      // R5: the visible level is the previous stage one clock later
      p_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
         q_o == $past(chain[CHAIN_W-WIDTH-1 -: WIDTH]));
   end

endmodule

// File: rtl/gpio_edge_detect.sv
module gpio_edge_detect #(
   parameter int unsigned NUM_PINS = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] lvl_i,
   input  logic [NUM_PINS-1:0] rise_en_i,
   input  logic [NUM_PINS-1:0] fall_en_i,
   input  logic [NUM_PINS-1:0] clr_i,
   output logic [NUM_PINS-1:0] status_o
);

   logic [NUM_PINS-1:0] prev_q;
   logic [NUM_PINS-1:0] status_q;
   logic [NUM_PINS-1:0] status_d;
   logic [NUM_PINS-1:0] evt;

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      logic went_up;
      logic went_down;
      assign went_up   =  lvl_i[i] & ~prev_q[i];
      assign went_down = ~lvl_i[i] &  prev_q[i];
      assign evt[i]    = (went_up & rise_en_i[i]) | (went_down & fall_en_i[i]);
      // a fresh event outranks a clear on the same edge
      assign status_d[i] = evt[i] | (status_q[i] & ~clr_i[i]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q   <= '0;
         status_q <= '0;
      end else begin
         prev_q   <= lvl_i;
         status_q <= status_d;
      end
   end

   assign status_o = status_q;

   // R9: an event always leaves its bit set, clear or not
   p_event_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (evt != '0) |=> ((status_q & $past(evt)) == $past(evt)));

   // R8: a clear with no event empties the bit
   p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i != '0) |=> ((status_q & $past(clr_i & ~evt)) == '0));

   // R8: bits not being cleared never drop
   p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(status_q & ~clr_i) & ~status_q) == '0));

   // R6: a bit can only become set where some enable was on
   p_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (((status_q & ~$past(status_q)) & ~$past(rise_en_i | fall_en_i)) == '0));

endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
   import gpio_bank_pkg::*;
#(
   parameter int unsigned NUM_PINS = 16,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned ADDR_W   = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                we_i,
   input  logic [ADDR_W-1:0]   addr_i,
   input  logic [DATA_W-1:0]   wdata_i,
   output logic [DATA_W-1:0]   rdata_o,
   input  logic [NUM_PINS-1:0] level_i,
   input  logic [NUM_PINS-1:0] status_i,
   output logic [NUM_PINS-1:0] out_o,
   output logic [NUM_PINS-1:0] dir_o,
   output logic [NUM_PINS-1:0] rise_en_o,
   output logic [NUM_PINS-1:0] fall_en_o,
   output logic [NUM_PINS-1:0] stat_clr_o
);

   localparam int unsigned PAD_W = DATA_W - NUM_PINS;

   logic                hi_zero;
   reg_sel_e            sel;
   reg_sel_e            sel_raw;
   logic [NUM_PINS-1:0] wmask;
   logic [NUM_PINS-1:0] out_q;
   logic [NUM_PINS-1:0] dir_q;
   logic [NUM_PINS-1:0] rise_q;
   logic [NUM_PINS-1:0] fall_q;
   logic [NUM_PINS-1:0] rd_pins;
   logic                wdata_unused;

   if (ADDR_W > 8) begin : g_wide_addr
      assign hi_zero = ~|addr_i[ADDR_W-1:8];
   end else begin : g_byte_addr
      assign hi_zero = 1'b1;
   end

   assign sel_raw      = decode_offset(addr_i[7:0]);
   assign sel          = hi_zero ? sel_raw : SEL_NONE;
   assign wmask        = wdata_i[NUM_PINS-1:0];
   assign wdata_unused = ^wdata_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q  <= '0;
         dir_q  <= '0;
         rise_q <= '0;
         fall_q <= '0;
      end else if (we_i) begin
         case (sel)
            SEL_SET:  out_q  <= out_q | wmask;
            SEL_CLR:  out_q  <= out_q & ~wmask;
            SEL_DIR:  dir_q  <= wmask;
            SEL_RISE: rise_q <= wmask;
            SEL_FALL: fall_q <= wmask;
            default:  ;
         endcase
      end
   end

   assign stat_clr_o = (we_i && sel == SEL_STAT) ? wmask : '0;

   always_comb begin
      case (sel)
         SEL_LEVEL: rd_pins = level_i;
         SEL_DIR:   rd_pins = dir_q;
         SEL_RISE:  rd_pins = rise_q;
         SEL_FALL:  rd_pins = fall_q;
         SEL_STAT:  rd_pins = status_i;
         default:   rd_pins = '0;
      endcase
   end

   if (PAD_W > 0) begin : g_pad
      assign rdata_o = {{PAD_W{1'b0}}, rd_pins};
   end else begin : g_full
      assign rdata_o = rd_pins;
   end

   assign out_o     = out_q;
   assign dir_o     = dir_q;
   assign rise_en_o = rise_q;
   assign fall_en_o = fall_q;

   // R2: set writes raise masked bits and touch nothing else
   p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (we_i && sel == SEL_SET) |=>
         (((out_q & $past(wmask)) == $past(wmask)) &&
          (((out_q ^ $past(out_q)) & ~$past(wmask)) == '0)));

   // R3: clear writes lower masked bits and touch nothing else
   p_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (we_i && sel == SEL_CLR) |=>
         (((out_q & $past(wmask)) == '0) &&
          (((out_q ^ $past(out_q)) & ~$past(wmask)) == '0)));

   // R4: direction follows a write and holds otherwise
   p_dir_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (we_i && sel == SEL_DIR) |=> (dir_q == $past(wmask)));
   p_dir_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(we_i && sel == SEL_DIR) |=> $stable(dir_q));

endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank #(
   parameter int unsigned NUM_PINS    = 16,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_we,
   input  logic [ADDR_W-1:0]   reg_addr,
   input  logic [DATA_W-1:0]   reg_wdata,
   output logic [DATA_W-1:0]   reg_rdata,
   input  logic [NUM_PINS-1:0] pin_in,
   output logic [NUM_PINS-1:0] pin_out,
   output logic [NUM_PINS-1:0] pin_oe,
   output logic                irq
);

   if (NUM_PINS < 1 || NUM_PINS > 32) begin : g_bad_pins
      $error("gpio_edge_bank: NUM_PINS must be 1..32");
   end
   if (NUM_PINS > DATA_W) begin : g_bad_data
      $error("gpio_edge_bank: DATA_W must hold NUM_PINS");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $error("gpio_edge_bank: ADDR_W must be at least 8");
   end

   logic [NUM_PINS-1:0] lvl_sync;
   logic [NUM_PINS-1:0] rise_en;
   logic [NUM_PINS-1:0] fall_en;
   logic [NUM_PINS-1:0] stat_clr;
   logic [NUM_PINS-1:0] status;

   gpio_pin_sync #(
      .WIDTH  (NUM_PINS),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (pin_in),
      .q_o   (lvl_sync)
   );

   gpio_bank_regs #(
      .NUM_PINS (NUM_PINS),
      .DATA_W   (DATA_W),
      .ADDR_W   (ADDR_W)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .we_i       (reg_we),
      .addr_i     (reg_addr),
      .wdata_i    (reg_wdata),
      .rdata_o    (reg_rdata),
      .level_i    (lvl_sync),
      .status_i   (status),
      .out_o      (pin_out),
      .dir_o      (pin_oe),
      .rise_en_o  (rise_en),
      .fall_en_o  (fall_en),
      .stat_clr_o (stat_clr)
   );

   gpio_edge_detect #(
      .NUM_PINS (NUM_PINS)
   ) u_edge (
      .clk       (clk),
      .rst_n     (rst_n),
      .lvl_i     (lvl_sync),
      .rise_en_i (rise_en),
      .fall_en_i (fall_en),
      .clr_i     (stat_clr),
      .status_o  (status)
   );

   assign irq = |status;

   // R10: with no clearing write the interrupt cannot drop
   p_irq_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && stat_clr == '0) |=> irq);

   // R10: the interrupt only rises when some edge enable was on
   p_irq_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> ($past(rise_en | fall_en) != '0));

endmodule

// File: tb/gpio_edge_bank_bench.sv
module gpio_edge_bank_bench;

   localparam int CLK_PERIOD = 10;
   localparam int NP         = 16;
   localparam int WD_LIMIT   = 100000;

   logic            clk   = 1'b0;
   logic            rst_n = 1'b0;
   logic            reg_we = 1'b0;
   logic [7:0]      reg_addr = 8'h00;
   logic [31:0]     reg_wdata = '0;
   logic [31:0]     reg_rdata;
   logic [NP-1:0]   pin_in = '0;
   logic [NP-1:0]   pin_out;
   logic [NP-1:0]   pin_oe;
   logic            irq;

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   gpio_edge_bank #(
      .NUM_PINS    (NP),
      .DATA_W      (32),
      .ADDR_W      (8),
      .SYNC_STAGES (2)
   ) u_gpio_edge_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_we    (reg_we),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .pin_in    (pin_in),
      .pin_out   (pin_out),
      .pin_oe    (pin_oe),
      .irq       (irq)
   );

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, got, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   logic [NP-1:0] hist[$];
   logic [NP-1:0] m_out, m_dir, m_ren, m_fen, m_stat, m_lvl;

   always @(posedge clk or negedge rst_n) begin
      logic [NP-1:0] ev;
      logic [NP-1:0] wm;
      logic [NP-1:0] clr;
      if (!rst_n) begin
         hist = '{'0, '0, '0};
         m_out = '0; m_dir = '0; m_ren = '0; m_fen = '0; m_stat = '0; m_lvl = '0;
      end else begin
         ev  = (hist[1] & ~hist[2] & m_ren) | (~hist[1] & hist[2] & m_fen);
         wm  = reg_wdata[NP-1:0];
         clr = '0;
         if (reg_we) begin
            case (reg_addr)
               8'h18: m_out = m_out | wm;
               8'h24: m_out = m_out & ~wm;
               8'h0C: m_dir = wm;
               8'h30: m_ren = wm;
               8'h3C: m_fen = wm;
               8'h48: clr = wm;
               default: ;
            endcase
         end
         m_stat = (m_stat & ~clr) | ev;
         hist.push_front(pin_in);
         void'(hist.pop_back());
         m_lvl = hist[1];
      end
   end

   function automatic logic [31:0] model_read(input logic [7:0] a);
      case (a)
         8'h00: return {16'h0, m_lvl};
         8'h0C: return {16'h0, m_dir};
         8'h30: return {16'h0, m_ren};
         8'h3C: return {16'h0, m_fen};
         8'h48: return {16'h0, m_stat};
         default: return 32'h0;
      endcase
   endfunction

   // per-clock comparison, away from the edge
   always @(posedge clk) begin
      #2;
      if (rst_n) begin
         check("R2/R3 cycle pin_out", {16'h0, pin_out}, {16'h0, m_out});
         check("R4 cycle pin_oe", {16'h0, pin_oe}, {16'h0, m_dir});
         check("R10 cycle irq", {31'h0, irq}, {31'h0, (m_stat != '0)});
         check("R5/R8/R11 cycle rdata", reg_rdata, model_read(reg_addr));
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0; reg_wdata = '0;
   endtask

   task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
      @(negedge clk);
      reg_addr = a;
      #1;
      check(tag, reg_rdata, exp);
   endtask

   task automatic set_pins(input logic [NP-1:0] v);
      @(negedge clk);
      pin_in = v;
      repeat (3) @(negedge clk);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (WD_LIMIT) @(posedge clk);
      n_bad++;
      $display("FAIL R1 watchdog actual=%0d expected<%0d cycles", WD_LIMIT, WD_LIMIT);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   // ---------------- main sequence ----------------
   initial begin
      logic [7:0] offs [8];
      offs = '{8'h00, 8'h0C, 8'h18, 8'h24, 8'h30, 8'h3C, 8'h48, 8'h04};

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      #1;
      check("R1 pin_oe", {16'h0, pin_oe}, 32'h0);
      check("R1 pin_out", {16'h0, pin_out}, 32'h0);
      check("R1 irq", {31'h0, irq}, 32'h0);
      rd(8'h0C, 32'h0, "R1 direction");
      rd(8'h30, 32'h0, "R1 rise enable");
      rd(8'h3C, 32'h0, "R1 fall enable");
      rd(8'h48, 32'h0, "R1 status");

      // R4 / R11 direction and unused bits
      wr(8'h0C, 32'hFFFF_00F0);
      rd(8'h0C, 32'h0000_00F0, "R4 R11 direction readback");
      check("R4 pin_oe", {16'h0, pin_oe}, 32'h0000_00F0);

      // R2 / R3 set and clear
      wr(8'h18, 32'hFFFF_0005);
      check("R2 set", {16'h0, pin_out}, 32'h0005);
      rd(8'h18, 32'h0, "R3 set reads zero");
      wr(8'h18, 32'h0000_0030);
      check("R2 zeros keep", {16'h0, pin_out}, 32'h0035);
      wr(8'h24, 32'h0000_0011);
      check("R3 clear", {16'h0, pin_out}, 32'h0024);
      rd(8'h24, 32'h0, "R3 clear reads zero");

      // R5 level latency
      @(negedge clk);
      pin_in = 16'h00A0;
      reg_addr = 8'h00;
      @(negedge clk); #1;
      check("R5 level not yet after one edge", reg_rdata, 32'h0);
      @(negedge clk); #1;
      check("R5 level after two edges", reg_rdata, 32'h00A0);
      set_pins(16'h000F);
      rd(8'h00, 32'h000F, "R5 level");
      rd(8'h48, 32'h0, "R6 no enable no status");
      set_pins(16'h0000);
      rd(8'h48, 32'h0, "R7 no enable no status");

      // enables
      wr(8'h30, 32'h0000_0003);
      wr(8'h3C, 32'h0000_0006);
      rd(8'h30, 32'h3, "R6 rise enable readback");
      rd(8'h3C, 32'h6, "R7 fall enable readback");

      set_pins(16'h0001);
      rd(8'h48, 32'h1, "R6 rise latched");
      check("R10 irq high", {31'h0, irq}, 32'h1);
      set_pins(16'h0003);
      rd(8'h48, 32'h3, "R6 second rise");
      set_pins(16'h0001);
      rd(8'h48, 32'h3, "R8 sticky");
      set_pins(16'h0005);
      rd(8'h48, 32'h3, "R6 rise on fall-only pin ignored");
      set_pins(16'h0001);
      rd(8'h48, 32'h7, "R7 fall latched");
      set_pins(16'h0009);
      rd(8'h48, 32'h7, "R6 disabled pin ignored");

      wr(8'h48, 32'h0);
      rd(8'h48, 32'h7, "R8 zero write no effect");
      wr(8'h48, 32'h2);
      rd(8'h48, 32'h5, "R8 one clears bit");
      set_pins(16'h000B);
      rd(8'h48, 32'h7, "R7 both enabled rise");
      wr(8'h48, 32'h2);
      set_pins(16'h0009);
      rd(8'h48, 32'h7, "R7 both enabled fall");

      // R9 event and clear on the same edge
      set_pins(16'h0008);
      rd(8'h48, 32'h7, "R9 setup");
      @(negedge clk);
      pin_in = 16'h0009;
      @(negedge clk);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = 8'h48; reg_wdata = 32'h1;
      @(negedge clk);
      reg_we = 1'b0; reg_wdata = '0;
      rd(8'h48, 32'h7, "R9 event beats clear");
      wr(8'h48, 32'h1);
      rd(8'h48, 32'h6, "R8 quiet clear");

      wr(8'h48, 32'hFFFF_FFFF);
      rd(8'h48, 32'h0, "R8 clear all");
      check("R10 irq low", {31'h0, irq}, 32'h0);

      // R11 unused bits and unmapped offset
      wr(8'h30, 32'hFFFF_FFFF);
      rd(8'h30, 32'h0000_FFFF, "R11 upper bits zero");
      rd(8'h04, 32'h0, "R11 unmapped offset");
      wr(8'h30, 32'h0);

      // randomised phase, judged by the model every clock
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         pin_in    = NP'($urandom);
         reg_we    = ($urandom_range(0, 2) == 0);
         reg_addr  = offs[$urandom_range(0, 7)];
         reg_wdata = $urandom;
      end
      @(negedge clk);
      reg_we = 1'b0;
      repeat (4) @(negedge clk);

      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule